// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt conditions of a 16550-style serial port and presents them as one read-only identification word. Its inputs are the raw conditions: a receive line error, receive data available, a character timeout, a one-cycle event marking the transmit holding register as empty, and level flags for auto-baud completion and auto-baud timeout. Alongside these it takes the interrupt-enable bits, the FIFO-enable control bit and a one-cycle register read strobe. It returns the word, a registered interrupt request and a clear pulse for the transmit-empty condition.

Only enabled sources compete for the priority code. The word is registered, and it holds its value across a read, so software sees a consistent snapshot. An event that lands in a read cycle is kept for the next read. Transmit-empty is the one latched source. A read that returns its code clears it. The receive-side sources follow their inputs.

Top module: `uart_int_id`

## Requirements
- R1: After reset, `iir_o` is 0x00000001 and `irq_o` and `thre_clr_o` are 0.
- R2: Bits 3:1 hold the code of the highest-priority pending source. From highest to lowest: line status 3'b011, data available 3'b010, character timeout 3'b110, transmit empty 3'b001. Bit 0 is 0 when any source is pending. With none pending, bit 0 is 1 and bits 3:1 are 3'b000.
- R3: A source is pending only if its enable bit is set. `ier_i[0]` gates data available and character timeout, `ier_i[1]` gates transmit empty, and `ier_i[2]` gates line status.
- R4: In a cycle with `rd_i` high, `iir_o` does not change at the closing edge. Changes that arrive in that cycle show up at the edge after the next one.
- R5: A `thre_set_i` pulse sets a transmit-empty latch. A read whose returned word shows code 3'b001 with bit 0 low drives `thre_clr_o` high in that cycle, and the latch clears at that edge.
- R6: A `thre_set_i` pulse that arrives in the same cycle as a clearing read leaves the latch set. The next word shows the transmit-empty code again.
- R7: A read does not clear line status, data available or character timeout. They follow their inputs only.
- R8: Bits 7 and 6 both copy `fifo_en_i`.
- R9: Bit 8 is `ab_done_i` AND `ier_i[9]`. Bit 9 is `ab_tmo_i` AND `ier_i[8]`.
- R10: Bits 5:4 and 31:10 read 0. The codes 3'b000 with bit 0 low, 3'b100, 3'b101 and 3'b111 never appear.
- R11: Outside read cycles, `iir_o` and `irq_o` take the state of the inputs one edge later. `irq_o` is the inverse of bit 0, ORed with bits 8 and 9, and it also updates during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rls_i | input | 1 | Receive line error condition, level |
| rda_i | input | 1 | Receive data available, level |
| cti_i | input | 1 | Character timeout, level |
| thre_set_i | input | 1 | Transmit holding register became empty, one-cycle pulse |
| ab_done_i | input | 1 | Auto-baud finished, level |
| ab_tmo_i | input | 1 | Auto-baud timed out, level |
| ier_i | input | IER_W | Interrupt enable bits |
| fifo_en_i | input | 1 | FIFO enable control bit |
| rd_i | input | 1 | Identification register read strobe, one cycle |
| iir_o | output | WORD_W | Identification word |
| irq_o | output | 1 | Interrupt request, registered |
| thre_clr_o | output | 1 | Transmit-empty clear pulse during a clearing read |

## Verification
The bench raises all three receive sources together and drops them one at a time, so it catches a swapped priority or a wrong code. It also enables the sources one at a time; a mistaken enable-bit mapping then shows the wrong code. The bench raises data available during a read, which a design without the freeze would show too early. It also fires a transmit-empty pulse inside a clearing read. A design where clear beats set would lose that event, and a design whose read clears everything would drop data available while the input is still high. The auto-baud flags are checked against crossed enable bits, and one read is done while they change.

// File: rtl/uart_int_id_pkg.sv
package uart_int_id_pkg;
  localparam int NSRC = 4;  // index 0 = highest priority

  typedef enum logic [2:0] {
    IID_NONE = 3'b000,
    IID_THRE = 3'b001,
    IID_RDA  = 3'b010,
    IID_RLS  = 3'b011,
    IID_CTI  = 3'b110
  } iid_e;

  function automatic iid_e src_code(input int idx);
    case (idx)
      0:       return IID_RLS;
      1:       return IID_RDA;
      2:       return IID_CTI;
      3:       return IID_THRE;
      default: return IID_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_int_id_src.sv
module uart_int_id_src
  import uart_int_id_pkg::*;
#(
  parameter int IER_W   = 10,
  parameter int EN_RX   = 0,
  parameter int EN_THRE = 1,
  parameter int EN_RLS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rls_i,
  input  logic             rda_i,
  input  logic             cti_i,
  input  logic             thre_set_i,
  input  logic             thre_clr_i,
  input  logic [IER_W-1:0] ier_i,
  output logic [NSRC-1:0]  pend_o
);
  logic thre_q;

  // set wins over clear so an event during a clearing read survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         thre_q <= 1'b0;
    else if (thre_set_i) thre_q <= 1'b1;
    else if (thre_clr_i) thre_q <= 1'b0;
  end

  always_comb begin
    pend_o[0] = rls_i  & ier_i[EN_RLS];
    pend_o[1] = rda_i  & ier_i[EN_RX];
    pend_o[2] = cti_i  & ier_i[EN_RX];
    pend_o[3] = thre_q & ier_i[EN_THRE];
  end

  assert_thre_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thre_clr_i && !thre_set_i) |=> !thre_q);
  assert_thre_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_set_i |=> thre_q);
endmodule

// File: rtl/uart_int_id_prio.sv
module uart_int_id_prio
  import uart_int_id_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic [2:0]      code_o,
  output logic            any_o
);
  always_comb begin
    code_o = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = src_code(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/uart_int_id.sv
module uart_int_id
  import uart_int_id_pkg::*;
#(
  parameter int IER_W  = 10,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rls_i,
  input  logic              rda_i,
  input  logic              cti_i,
  input  logic              thre_set_i,
  input  logic              ab_done_i,
  input  logic              ab_tmo_i,
  input  logic [IER_W-1:0]  ier_i,
  input  logic              fifo_en_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] iir_o,
  output logic              irq_o,
  output logic              thre_clr_o
);
  localparam int EN_RX      = 0;
  localparam int EN_THRE    = 1;
  localparam int EN_RLS     = 2;
  localparam int EN_AB_TMO  = 8;
  localparam int EN_AB_DONE = 9;
  localparam int B_PEND_N   = 0;
  localparam int B_CODE_LO  = 1;
  localparam int B_CODE_HI  = 3;
  localparam int B_FIFO_LO  = 6;
  localparam int B_FIFO_HI  = 7;
  localparam int B_AB_DONE  = 8;
  localparam int B_AB_TMO   = 9;
  localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(1);

  logic [NSRC-1:0]   pend;
  logic [2:0]        code;
  logic              any;
  logic [WORD_W-1:0] live;

  uart_int_id_src #(
    .IER_W(IER_W), .EN_RX(EN_RX), .EN_THRE(EN_THRE), .EN_RLS(EN_RLS)
  ) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rls_i     (rls_i),
    .rda_i     (rda_i),
    .cti_i     (cti_i),
    .thre_set_i(thre_set_i),
    .thre_clr_i(thre_clr_o),
    .ier_i     (ier_i),
    .pend_o    (pend)
  );

  uart_int_id_prio u_prio (
    .pend_i(pend),
    .code_o(code),
    .any_o (any)
  );

  always_comb begin
    live = '0;
    live[B_PEND_N]              = ~any;
    live[B_CODE_HI:B_CODE_LO]   = code;
    live[B_FIFO_HI:B_FIFO_LO]   = {2{fifo_en_i}};
    live[B_AB_DONE]             = ab_done_i & ier_i[EN_AB_DONE];
    live[B_AB_TMO]              = ab_tmo_i  & ier_i[EN_AB_TMO];
  end

  // word freezes during a read; request keeps tracking live state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iir_o <= RST_WORD;
      irq_o <= 1'b0;
    end else begin
      if (!rd_i) iir_o <= live;
      irq_o <= ~live[B_PEND_N] | live[B_AB_DONE] | live[B_AB_TMO];
    end
  end

  assign thre_clr_o = rd_i & ~iir_o[B_PEND_N] & (iir_o[B_CODE_HI:B_CODE_LO] == IID_THRE);

  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> $stable(iir_o));
  assert_idle_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[B_PEND_N] |-> (iir_o[B_CODE_HI:B_CODE_LO] == IID_NONE));
  assert_legal_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iir_o[B_PEND_N] |-> (iir_o[B_CODE_HI:B_CODE_LO] inside {IID_THRE, IID_RDA, IID_RLS, IID_CTI}));
  assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[5:4] == 2'b00) && (iir_o[WORD_W-1:10] == '0));
  assert_irq_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> (irq_o == (~iir_o[B_PEND_N] | iir_o[B_AB_DONE] | iir_o[B_AB_TMO])));
  assert_clr_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_clr_o |-> rd_i);
endmodule

// File: tb/sim_uart_int_id.sv
`timescale 1ns/1ps
module sim_uart_int_id;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rls, rda, cti, thre_set, ab_done, ab_tmo, fifo_en, rd;
  logic [9:0]  ier;
  logic [31:0] iir;
  logic        irq, thre_clr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] w;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  uart_int_id u0 (
    .clk_i(clk), .rst_ni(rst_n), .rls_i(rls), .rda_i(rda), .cti_i(cti),
    .thre_set_i(thre_set), .ab_done_i(ab_done), .ab_tmo_i(ab_tmo),
    .ier_i(ier), .fifo_en_i(fifo_en), .rd_i(rd),
    .iir_o(iir), .irq_o(irq), .thre_clr_o(thre_clr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // in = {rd, ab_tmo, ab_done, thre_set, cti, rda, rls}
  task automatic cyc(input logic [6:0] in, input logic [9:0] en, input logic fen,
                     input logic [31:0] exp_w, input logic exp_irq, input logic exp_clr,
                     input string tag);
    @(negedge clk);
    {rd, ab_tmo, ab_done, thre_set, cti, rda, rls} = in;
    ier = en;
    fifo_en = fen;
    #1;
    chk({31'b0, thre_clr}, {31'b0, exp_clr}, {tag, " thre_clr"});
    @(posedge clk);
    sb.push_back('{w: exp_w, irq: exp_irq, tag: tag});
  endtask

  // monitor: compare outputs after each edge against the queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(iir, e.w, {e.tag, " iir"});
        chk({31'b0, irq}, {31'b0, e.irq}, {e.tag, " irq"});
      end
    end
  end

  localparam logic [9:0] ALL = 10'h307;
  localparam logic [6:0] N = 7'b0000000, RLS = 7'b0000001, RDA = 7'b0000010,
                         CTI = 7'b0000100, THR = 7'b0001000, ABD = 7'b0010000,
                         ABT = 7'b0100000, RD = 7'b1000000;

  initial begin
    {rd, ab_tmo, ab_done, thre_set, cti, rda, rls} = '0;
    ier = '0;
    fifo_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(iir, 32'h1, "R1 reset iir");
    chk({30'b0, irq, thre_clr}, 32'h0, "R1 reset irq/clr");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iir, 32'h1, "R1 after release");

    cyc(RLS|RDA|CTI, ALL, 1, 32'hC6, 1, 0, "R2 rls wins");
    cyc(RDA|CTI,     ALL, 1, 32'hC4, 1, 0, "R2 rda over cti");
    cyc(CTI,         ALL, 1, 32'hCC, 1, 0, "R2 cti alone");
    cyc(THR,         ALL, 1, 32'hC1, 0, 0, "R5 thre set edge");
    cyc(N,           ALL, 1, 32'hC2, 1, 0, "R5 thre shown");
    cyc(RD,          ALL, 1, 32'hC2, 1, 1, "R5 clearing read");
    cyc(N,           ALL, 1, 32'hC1, 0, 0, "R5 thre cleared");
    cyc(RD|RDA,      ALL, 1, 32'hC1, 1, 0, "R4 frozen during read");
    cyc(RDA,         ALL, 1, 32'hC4, 1, 0, "R4 held event shown");
    cyc(RD|RDA,      ALL, 1, 32'hC4, 1, 0, "R7 read of rda");
    cyc(RDA,         ALL, 1, 32'hC4, 1, 0, "R7 rda not cleared");
    cyc(THR,         ALL, 1, 32'hC1, 0, 0, "R6 thre set");
    cyc(N,           ALL, 1, 32'hC2, 1, 0, "R6 thre shown");
    cyc(RD|THR,      ALL, 1, 32'hC2, 1, 1, "R6 set during clearing read");
    cyc(N,           ALL, 1, 32'hC2, 1, 0, "R6 thre survives");
    cyc(RLS|RDA|CTI, 10'h000, 1, 32'hC1, 0, 0, "R3 all disabled");
    cyc(RLS|RDA|CTI, 10'h002, 1, 32'hC2, 1, 0, "R3 only thre enabled");
    cyc(RLS|RDA|CTI, 10'h004, 1, 32'hC6, 1, 0, "R3 only rls enabled");
    cyc(RLS|RDA|CTI, 10'h001, 1, 32'hC4, 1, 0, "R3 rx enable");
    cyc(CTI,         10'h001, 1, 32'hCC, 1, 0, "R3 rx enable gates cti");
    cyc(N,           10'h000, 0, 32'h01, 0, 0, "R8 fifo off");
    cyc(ABD,         10'h200, 1, 32'h1C1, 1, 0, "R9 ab done enabled");
    cyc(ABD,         10'h100, 1, 32'hC1, 0, 0, "R9 ab done crossed enable");
    cyc(ABT,         10'h100, 1, 32'h2C1, 1, 0, "R9 ab timeout enabled");
    cyc(RD|ABD|ABT,  10'h300, 1, 32'h2C1, 1, 0, "R4 freeze ab flags");
    cyc(ABD|ABT,     10'h300, 1, 32'h3C1, 1, 0, "R9 both flags");
    cyc(N,           10'h000, 1, 32'hC1, 0, 0, "R11 request drops");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule